// File: doc/BRIEF.md
# Bit-Parallel NFA Stream Matcher

This block scans a byte stream against one regular expression that has been compiled into a nondeterministic automaton. Each automaton state owns one bit of an active-state vector, so every state advances in parallel on each byte. Two programmable tables drive the update. A reachability matrix holds, for each state, the set of states it can move to. A character table holds, for each byte value, the set of states that accept that byte.

On each consumed byte the block ORs together the reachability rows of all active states, then ORs in a programmable start vector. The start vector is added on every byte, so a match may begin at any stream position. The result is masked with the character-table entry for the byte. A match flag is raised while any state in a programmable accepting set is active, and a counter reports how many bytes have been consumed since the last clear.

The host loads the tables through a configuration write port before streaming. The host then presents bytes with a valid strobe, and uses a synchronous clear between streams.

Top module: `nfa_matcher`

## Requirements
- R1: State k of the automaton is bit k of every state-sized vector (bit 0 is the root state). After reset: state_o = 0, match_o = 0, count_o = 0, start vector = 0x01 (root only), accepting set = 0, all reachability rows = 0.
- R2: A byte accepted (in_valid high) at clock edge k is reflected in state_o, match_o and count_o after edge k+1. Bytes may be presented on consecutive cycles.
- R3: Each consumed byte b sets the state vector to (OR of the reachability rows of all active states | start vector) & char_mask[b]. With the root reaching states 1 and 3, char_mask['/'] = 0x21 and char_mask['f'] = 0x22, the input "/f" gives 0x01 and then 0x02.
- R4: While no byte is consumed, state_o, match_o and count_o hold their values.
- R5: clr high at an edge zeroes the state vector, match_o and count_o at that edge. It also discards both the byte in flight and any byte presented in the same cycle, and it leaves all tables and masks unchanged.
- R6: match_o is 1 exactly when (state vector & accepting set) is nonzero, and it is updated together with state_o.
- R7: count_o increases by one for each consumed byte and returns to zero on clr or reset.
- R8: A configuration write (cfg_we = 1) selects its target with cfg_sel. Value 0 writes reachability row cfg_addr, where data bit j marks next state j. Value 1 writes char_mask[cfg_addr]. Value 2 writes the start vector. Value 3 writes the accepting set. No write changes state_o.
- R9: Because the start vector joins every step, overlapping and late-starting matches are found. With the pattern "ab" (root accepts 'a', state 1 accepts 'b', root reaches state 1), the stream "xaab" ends with match_o = 1. If the start vector is zero, nothing ever becomes active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of state, match and count |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Write target: 0 row, 1 char mask, 2 start, 3 accepting |
| cfg_addr | input | 8 | Row index or byte value |
| cfg_data | input | NSTATE | Data written |
| in_valid | input | 1 | Input byte valid |
| in_byte | input | 8 | Input byte |
| state_o | output | NSTATE | Active-state vector |
| match_o | output | 1 | An accepting state is active |
| count_o | output | CNT_W | Bytes consumed since clear |

## Verification
A clear and a byte step can arrive in the same cycle, and the clear must also kill the byte still in flight from the previous cycle. The bench provokes this by streaming one byte, then holding clr and in_valid high together on the next cycle. Several cycles later it requires a zero vector and a zero count. It then repeats the pattern stream to show that the tables survived and that no ghost step of the discarded bytes occurred.

// File: rtl/nfa_pkg.sv
package nfa_pkg;
  typedef enum logic [1:0] {
    CFG_ROW   = 2'd0,
    CFG_CHAR  = 2'd1,
    CFG_START = 2'd2,
    CFG_ACC   = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/nfa_reach.sv
module nfa_reach #(
  parameter int NSTATE = 8,
  parameter int AW     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [NSTATE-1:0] data,
  input  logic [NSTATE-1:0] active,
  output logic [NSTATE-1:0] reach
);
  logic [NSTATE-1:0] rows [NSTATE];

  // one register row per state; all rows are read every cycle
  for (genvar i = 0; i < NSTATE; i++) begin : g_row
    always_ff @(posedge clk) begin
      if (rst)
        rows[i] <= '0;
      else if (we && addr == AW'(i))
        rows[i] <= data;
    end
  end

  always_comb begin
    reach = '0;
    for (int i = 0; i < NSTATE; i++)
      if (active[i]) reach = reach | rows[i];
  end
endmodule

// File: rtl/nfa_accept.sv
module nfa_accept #(
  parameter int NSTATE = 8,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [BYTE_W-1:0] waddr,
  input  logic [NSTATE-1:0] wdata,
  input  logic [BYTE_W-1:0] raddr,
  output logic [NSTATE-1:0] rdata
);
  localparam int DEPTH = 1 << BYTE_W;
  logic [NSTATE-1:0] mem [DEPTH];

  // simple dual-port, registered read: block RAM friendly
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/nfa_step.sv
module nfa_step #(
  parameter int NSTATE = 8,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              in_valid,
  input  logic              start_we,
  input  logic              acc_we,
  input  logic [NSTATE-1:0] cfg_data,
  input  logic [NSTATE-1:0] char_mask,
  input  logic [NSTATE-1:0] reach,
  output logic [NSTATE-1:0] state,
  output logic              match,
  output logic [CNT_W-1:0]  count
);
  localparam logic [NSTATE-1:0] ROOT = NSTATE'(1);

  logic              vld_q;
  logic [NSTATE-1:0] start_q, acc_q, v_q, v_next;
  logic              match_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              step;

  assign step   = vld_q && !clr;
  assign v_next = (reach | start_q) & char_mask;

  always_ff @(posedge clk) begin
    if (rst || clr) vld_q <= 1'b0;
    else            vld_q <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= ROOT;
      acc_q   <= '0;
    end else begin
      if (start_we) start_q <= cfg_data;
      if (acc_we)   acc_q   <= cfg_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      v_q     <= '0;
      match_q <= 1'b0;
      cnt_q   <= '0;
    end else if (step) begin
      v_q     <= v_next;
      match_q <= |(v_next & acc_q);
      cnt_q   <= cnt_q + CNT_W'(1);
    end
  end

  assign state = v_q;
  assign match = match_q;
  assign count = cnt_q;

  // R3: new vector never holds a state the byte does not accept
  a_r3_subset: assert property (@(posedge clk) disable iff (rst)
    step |=> ((v_q & ~$past(char_mask)) == '0));
  // R4: no consumed byte, no change
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    (!vld_q && !clr) |=> ($stable(v_q) && $stable(cnt_q) && $stable(match_q)));
  // R5: clear empties state, flag and counter
  a_r5_clear: assert property (@(posedge clk) disable iff (rst)
    clr |=> (v_q == '0 && cnt_q == '0 && !match_q));
  // R6: a match needs an active state
  a_r6_match_active: assert property (@(posedge clk) disable iff (rst)
    match_q |-> (v_q != '0));
  // R7: one count per consumed byte
  a_r7_count: assert property (@(posedge clk) disable iff (rst)
    step |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));
endmodule

// File: rtl/nfa_matcher.sv
module nfa_matcher #(
  parameter int NSTATE = 8,
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [BYTE_W-1:0] cfg_addr,
  input  logic [NSTATE-1:0] cfg_data,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  output logic [NSTATE-1:0] state_o,
  output logic              match_o,
  output logic [CNT_W-1:0]  count_o
);
  import nfa_pkg::*;

  logic              row_we, char_we, start_we, acc_we;
  logic [NSTATE-1:0] reach, char_mask;

  assign row_we   = cfg_we && (cfg_sel == CFG_ROW);
  assign char_we  = cfg_we && (cfg_sel == CFG_CHAR);
  assign start_we = cfg_we && (cfg_sel == CFG_START);
  assign acc_we   = cfg_we && (cfg_sel == CFG_ACC);

  nfa_reach #(.NSTATE(NSTATE), .AW(BYTE_W)) u_reach (
    .clk(clk), .rst(rst), .we(row_we), .addr(cfg_addr), .data(cfg_data),
    .active(state_o), .reach(reach)
  );

  nfa_accept #(.NSTATE(NSTATE), .BYTE_W(BYTE_W)) u_accept (
    .clk(clk), .we(char_we), .waddr(cfg_addr), .wdata(cfg_data),
    .raddr(in_byte), .rdata(char_mask)
  );

  nfa_step #(.NSTATE(NSTATE), .CNT_W(CNT_W)) u_step (
    .clk(clk), .rst(rst), .clr(clr), .in_valid(in_valid),
    .start_we(start_we), .acc_we(acc_we), .cfg_data(cfg_data),
    .char_mask(char_mask), .reach(reach),
    .state(state_o), .match(match_o), .count(count_o)
  );
endmodule

// File: tb/tb_nfa_matcher.sv
module tb_nfa_matcher;
  localparam int N = 8;
  localparam int CW = 32;

  logic clk = 0, rst = 1, clr = 0, cfg_we = 0, in_valid = 0;
  logic [1:0] cfg_sel = 0;
  logic [7:0] cfg_addr = 0, in_byte = 0;
  logic [N-1:0] cfg_data = 0;
  logic [N-1:0] state_o;
  logic match_o;
  logic [CW-1:0] count_o;

  always #2 clk = ~clk;

  nfa_matcher #(.NSTATE(N), .BYTE_W(8), .CNT_W(CW)) dut (
    .clk(clk), .rst(rst), .clr(clr), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_addr(cfg_addr), .cfg_data(cfg_data), .in_valid(in_valid),
    .in_byte(in_byte), .state_o(state_o), .match_o(match_o), .count_o(count_o)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  logic [N-1:0] m_row [N];
  logic [N-1:0] m_chr [256];
  logic [N-1:0] m_start = 8'h01, m_acc = 0, m_v = 0;
  logic m_match = 0;
  int m_cnt = 0;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_all(string req);
    chk(req, 64'(state_o), 64'(m_v));
    chk(req, 64'(match_o), 64'(m_match));
    chk(req, 64'(count_o), 64'(m_cnt));
  endtask

  task automatic model_step(logic [7:0] b);
    logic [N-1:0] r = '0;
    for (int i = 0; i < N; i++) if (m_v[i]) r = r | m_row[i];
    m_v = (r | m_start) & m_chr[b];
    m_match = |(m_v & m_acc);
    m_cnt++;
  endtask

  task automatic cfg(logic [1:0] sel, logic [7:0] a, logic [N-1:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_sel = sel; cfg_addr = a; cfg_data = d;
    @(negedge clk);
    cfg_we = 0;
    case (sel)
      2'd0: m_row[a[2:0]] = d;
      2'd1: m_chr[a] = d;
      2'd2: m_start = d;
      default: m_acc = d;
    endcase
  endtask

  task automatic send(logic [7:0] b);
    @(negedge clk); in_valid = 1; in_byte = b;
    @(negedge clk); in_valid = 0;
    @(negedge clk);
    model_step(b);
  endtask

  task automatic stream(string s);
    for (int i = 0; i < s.len(); i++) begin
      @(negedge clk); in_valid = 1; in_byte = s[i];
      model_step(s[i]);
    end
    @(negedge clk); in_valid = 0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 reset state", 64'(state_o), 0);
    chk("R1 reset match", 64'(match_o), 0);
    chk("R1 reset count", 64'(count_o), 0);
  endtask

  task automatic t_example;
    cfg(2'd0, 8'd0, 8'h0A);
    cfg(2'd1, "/", 8'h21);
    cfg(2'd1, "f", 8'h22);
    send("/");
    chk("R3 after slash", 64'(state_o), 64'h01);
    chk("R2 count after slash", 64'(count_o), 1);
    send("f");
    chk("R3 after f", 64'(state_o), 64'h02);
    chk_all("R3 model");
  endtask

  task automatic t_overlap;
    cfg(2'd1, "/", 8'h00);
    cfg(2'd1, "f", 8'h00);
    cfg(2'd0, 8'd0, 8'h02);
    cfg(2'd1, "a", 8'h01);
    cfg(2'd1, "b", 8'h02);
    cfg(2'd3, 8'd0, 8'h02);
    send("x"); send("a"); send("a");
    chk("R9 no match yet", 64'(match_o), 0);
    send("b");
    chk("R9 overlap match", 64'(match_o), 1);
    chk("R6 state on match", 64'(state_o), 64'h02);
    send("c");
    chk("R6 match drops", 64'(match_o), 0);
    chk("R7 count", 64'(count_o), 64'(m_cnt));
  endtask

  task automatic t_hold;
    send("a");
    repeat (5) @(negedge clk);
    chk_all("R4 hold idle");
    cfg(2'd1, "z", 8'h55);
    chk("R8 cfg keeps state", 64'(state_o), 64'h01);
  endtask

  task automatic t_clear_collide;
    @(negedge clk); in_valid = 1; in_byte = "b";
    @(negedge clk); clr = 1; in_valid = 1; in_byte = "a";
    @(negedge clk); clr = 0; in_valid = 0;
    repeat (3) @(negedge clk);
    m_v = 0; m_match = 0; m_cnt = 0;
    chk_all("R5 clear with step");
    send("b");
    chk("R5 no ghost", 64'(state_o), 0);
    stream("ab");
    chk("R5 tables kept", 64'(match_o), 1);
    chk_all("R5 model");
  endtask

  task automatic t_stream;
    stream("xababba");
    chk_all("R2 back to back");
    stream("aab");
    chk("R2 stream match", 64'(match_o), 1);
    chk_all("R7 stream");
  endtask

  task automatic t_no_start;
    cfg(2'd2, 8'd0, 8'h00);
    stream("abab");
    chk("R9 zero start", 64'(state_o), 0);
    chk("R8 start write", 64'(match_o), 0);
  endtask

  task automatic report;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    for (int i = 0; i < N; i++) m_row[i] = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    for (int i = 0; i < 256; i++) cfg(2'd1, 8'(i), '0);
    t_example();
    t_overlap();
    t_hold();
    t_clear_collide();
    t_stream();
    t_no_start();
    done = 1;
    report();
  end
endmodule